// File: doc/BRIEF.md
# Handshaked Shift Computation Unit

This block is a small computation unit that performs one logical shift per transaction. A single-cycle issue pulse starts the transaction and also captures a direction bit. The unit then requests its two operands, each on its own port with a release output and a go input. Operand A is the value to be shifted. Operand B supplies the shift amount. Once both operands are held, the unit computes the shifted value. It offers that value on a result port that uses the same release/go handshake.

The agent on the other side of each port may answer a release with go in the same cycle, or any number of cycles later. Operand ports are independent of each other, so their go pulses can arrive in either order. A busy flag covers the whole transaction. An issue pulse that arrives while the unit is busy has no effect.

Top module: `shift_cu`

## Requirements
- R1: An issue_i pulse while busy_o is low causes, in the next cycle, busy_o high and both opa_rel_o and opb_rel_o high. dir_i is sampled in the issue cycle.
- R2: dir_i = 1 selects a logical right shift of A and dir_i = 0 selects a left shift of A, truncated to WIDTH bits. The shift amount is B[log2(WIDTH)-1:0]. For example, 13 >> 2 = 3 and 3 << 4 = 48.
- R3: A shift amount of 0 returns A unchanged, in either direction.
- R4: An operand is captured only in a cycle where its go input is high while its release output is high. A go while the release is low is ignored. The release output falls in the cycle after the accepted go.
- R5: The operands may arrive in either order, including in the same cycle as their release. res_rel_o rises in the cycle after the later operand go, carrying the computed result.
- R6: res_rel_o stays high, and res_data_o stays stable, until res_go_i is high. res_data_o carries the result during the go cycle.
- R7: In the cycle after res_go_i is accepted, res_rel_o and busy_o are both low.
- R8: issue_i while busy_o is high is ignored. The running transaction keeps its original direction and operands.
- R9: A synchronous active-high rst clears busy_o and every release output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | One-cycle start pulse |
| dir_i | input | 1 | Direction: 1 right, 0 left |
| opa_rel_o | output | 1 | Requests operand A |
| opa_go_i | input | 1 | Operand A present |
| opa_data_i | input | WIDTH | Operand A value |
| opb_rel_o | output | 1 | Requests operand B |
| opb_go_i | input | 1 | Operand B present |
| opb_data_i | input | WIDTH | Operand B, shift amount in low bits |
| res_rel_o | output | 1 | Result offered |
| res_go_i | input | 1 | Result accepted |
| res_data_o | output | WIDTH | Result value |
| busy_o | output | 1 | Transaction in progress |

## Verification
Every output of this block is registered, so each response is due exactly one cycle after the edge that causes it. The operand releases and busy_o rise one cycle after issue. res_rel_o rises one cycle after the later operand go. busy_o and res_rel_o fall one cycle after the result go. The bench drives inputs on the falling edge and compares every output against its behavioural model at the next falling edge, which lies half a period after the rising edge where the change is due. The operand and result delays cover zero, one and several cycles, in both arrival orders.

// File: rtl/shift_cu_pkg.sv
package shift_cu_pkg;
    typedef enum logic [1:0] {
        CU_IDLE  = 2'd0,
        CU_FETCH = 2'd1,
        CU_OFFER = 2'd2
    } cu_state_e;
endpackage

// File: rtl/shift_cu_opnd.sv
module shift_cu_opnd #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             go_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             rel_o,
    output logic             have_o,
    output logic [WIDTH-1:0] val_o
);
    typedef struct packed {
        logic             rel;
        logic             have;
        logic [WIDTH-1:0] val;
    } port_s;

    port_s port_d, port_q;
    logic  take;

    always_comb begin
        take   = port_q.rel & go_i;
        port_d = port_q;
        if (start_i) begin
            port_d.rel  = 1'b1;
            port_d.have = 1'b0;
        end else if (take) begin
            port_d.rel  = 1'b0;
            port_d.have = 1'b1;
            port_d.val  = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) port_q <= '0;
        else     port_q <= port_d;
    end

    assign rel_o  = port_q.rel;
    assign have_o = port_q.have | take;
    assign val_o  = take ? data_i : port_q.val;

    assert_rel_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (rel_o && go_i && !start_i) |=> !rel_o);
    assert_go_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (!rel_o && go_i && !start_i) |=> !rel_o && $stable(port_q.val));
endmodule

// File: rtl/shift_cu_shifter.sv
module shift_cu_shifter #(
    parameter int WIDTH = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic             dir_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [SHW-1:0]   amt_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        if (dir_i) res_o = a_i >> amt_i;
        else       res_o = a_i << amt_i;
        if (amt_i == '0) begin
            assert_zero_pass_R3: assert (res_o == a_i);
        end
    end
endmodule

// File: rtl/shift_cu_result.sv
module shift_cu_result #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] value_i,
    input  logic             go_i,
    output logic             rel_o,
    output logic [WIDTH-1:0] data_o,
    output logic             done_o
);
    typedef struct packed {
        logic             rel;
        logic [WIDTH-1:0] data;
    } res_s;

    res_s res_d, res_q;

    always_comb begin
        res_d  = res_q;
        done_o = res_q.rel & go_i;
        if (load_i) begin
            res_d.rel  = 1'b1;
            res_d.data = value_i;
        end else if (done_o) begin
            res_d.rel  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign rel_o  = res_q.rel;
    assign data_o = res_q.data;

    assert_hold_until_go_R6: assert property (@(posedge clk) disable iff (rst)
        (rel_o && !go_i) |=> rel_o && $stable(data_o));
endmodule

// File: rtl/shift_cu.sv
module shift_cu #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  logic             dir_i,
    output logic             opa_rel_o,
    input  logic             opa_go_i,
    input  logic [WIDTH-1:0] opa_data_i,
    output logic             opb_rel_o,
    input  logic             opb_go_i,
    input  logic [WIDTH-1:0] opb_data_i,
    output logic             res_rel_o,
    input  logic             res_go_i,
    output logic [WIDTH-1:0] res_data_o,
    output logic             busy_o
);
    import shift_cu_pkg::*;

    localparam int NUM_OPS = 2;
    localparam int SHW     = $clog2(WIDTH);

    typedef struct packed {
        cu_state_e state;
        logic      dir;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic                 start, load, res_done, all_have;
    logic [NUM_OPS-1:0]   op_go, op_rel, op_have;
    logic [WIDTH-1:0]     op_in  [NUM_OPS];
    logic [WIDTH-1:0]     op_val [NUM_OPS];
    logic [WIDTH-1:0]     shifted;

    assign op_go    = {opb_go_i, opa_go_i};
    assign op_in[0] = opa_data_i;
    assign op_in[1] = opb_data_i;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_opnd
        shift_cu_opnd #(.WIDTH(WIDTH)) u_opnd (
            .clk    (clk),
            .rst    (rst),
            .start_i(start),
            .go_i   (op_go[g]),
            .data_i (op_in[g]),
            .rel_o  (op_rel[g]),
            .have_o (op_have[g]),
            .val_o  (op_val[g])
        );
    end

    assign opa_rel_o = op_rel[0];
    assign opb_rel_o = op_rel[1];
    assign all_have  = &op_have;

    shift_cu_shifter #(.WIDTH(WIDTH)) u_shift (
        .dir_i(ctl_q.dir),
        .a_i  (op_val[0]),
        .amt_i(op_val[1][SHW-1:0]),
        .res_o(shifted)
    );

    shift_cu_result #(.WIDTH(WIDTH)) u_res (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .value_i(shifted),
        .go_i   (res_go_i),
        .rel_o  (res_rel_o),
        .data_o (res_data_o),
        .done_o (res_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        start = 1'b0;
        load  = 1'b0;
        case (ctl_q.state)
            CU_IDLE: begin
                if (issue_i) begin
                    start       = 1'b1;
                    ctl_d.dir   = dir_i;
                    ctl_d.state = CU_FETCH;
                end
            end
            CU_FETCH: begin
                if (all_have) begin
                    load        = 1'b1;
                    ctl_d.state = CU_OFFER;
                end
            end
            CU_OFFER: begin
                if (res_done) ctl_d.state = CU_IDLE;
            end
            default: ctl_d.state = CU_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{state: CU_IDLE, dir: 1'b0};
        else     ctl_q <= ctl_d;
    end

    assign busy_o = (ctl_q.state != CU_IDLE);

    assert_issue_starts_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && issue_i) |=> busy_o && opa_rel_o && opb_rel_o);
    assert_busy_issue_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && issue_i && !res_done) |=> busy_o && $stable(ctl_q.dir));
    assert_done_frees_R7: assert property (@(posedge clk) disable iff (rst)
        (res_rel_o && res_go_i) |=> !busy_o && !res_rel_o);
    assert_rel_within_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (res_rel_o || opa_rel_o || opb_rel_o) |-> busy_o);
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> !busy_o && !res_rel_o && !opa_rel_o && !opb_rel_o);
endmodule

// File: tb/shift_cu_test.sv
module shift_cu_test;
    localparam int W      = 16;
    localparam int CLK_NS = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic issue_i = 0, dir_i = 0;
    logic opa_go_i = 0, opb_go_i = 0, res_go_i = 0;
    logic [W-1:0] opa_data_i = 0, opb_data_i = 0;
    logic opa_rel_o, opb_rel_o, res_rel_o, busy_o;
    logic [W-1:0] res_data_o;

    int checks = 0, fails = 0;

    always #(CLK_NS/2) clk = ~clk;

    shift_cu #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .dir_i(dir_i),
        .opa_rel_o(opa_rel_o), .opa_go_i(opa_go_i), .opa_data_i(opa_data_i),
        .opb_rel_o(opb_rel_o), .opb_go_i(opb_go_i), .opb_data_i(opb_data_i),
        .res_rel_o(res_rel_o), .res_go_i(res_go_i), .res_data_o(res_data_o),
        .busy_o(busy_o)
    );

    function automatic logic [W-1:0] exp_shift(input logic [W-1:0] a, b, input logic d);
        int amt = int'(b) % W;
        return d ? (a >> amt) : (a << amt);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_busy, m_arel, m_brel, m_rrel, m_ha, m_hb, m_dir;
    logic [W-1:0] m_a, m_b, m_res;

    always @(posedge clk) begin
        bit ta, tb;
        if (rst) begin
            m_busy = 0; m_arel = 0; m_brel = 0; m_rrel = 0; m_ha = 0; m_hb = 0;
        end else if (!m_busy) begin
            if (issue_i) begin
                m_busy = 1; m_arel = 1; m_brel = 1; m_ha = 0; m_hb = 0; m_dir = dir_i;
            end
        end else if (m_rrel) begin
            if (res_go_i) begin m_rrel = 0; m_busy = 0; end
        end else begin
            ta = m_arel && opa_go_i;
            tb = m_brel && opb_go_i;
            if (ta) begin m_arel = 0; m_ha = 1; m_a = opa_data_i; end
            if (tb) begin m_brel = 0; m_hb = 1; m_b = opb_data_i; end
            if (m_ha && m_hb) begin m_rrel = 1; m_res = exp_shift(m_a, m_b, m_dir); end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R1/R7 busy_o", W'(busy_o), W'(m_busy));
            chk("R4 opa_rel_o", W'(opa_rel_o), W'(m_arel));
            chk("R4 opb_rel_o", W'(opb_rel_o), W'(m_brel));
            chk("R6 res_rel_o", W'(res_rel_o), W'(m_rrel));
            if (m_rrel) chk("R6 res_data_o", res_data_o, m_res);
        end
    end

    task automatic txn(input logic [W-1:0] a, b, input logic d,
                       input int da, db, dr, input bit poke);
        bit adone = 0, bdone = 0;
        int c = 0;
        logic [W-1:0] exp = exp_shift(a, b, d);
        @(negedge clk);
        issue_i = 1; dir_i = d;
        while (!(adone && bdone)) begin
            @(negedge clk);
            issue_i = (c == 0) && poke;
            dir_i   = ~d;
            opa_go_i = (c == da); opa_data_i = (c == da) ? a : 16'hBEEF;
            opb_go_i = (c == db); opb_data_i = (c == db) ? b : 16'h0007;
            if (c == da) adone = 1;
            if (c == db) bdone = 1;
            c++;
        end
        @(negedge clk);
        issue_i = 0; opa_go_i = 0; opb_go_i = 0; opa_data_i = 16'h1234; opb_data_i = 16'h0003;
        chk("R5 result offered after later operand", W'(res_rel_o), W'(1));
        repeat (dr) @(negedge clk);
        chk("R6 rel held until go", W'(res_rel_o), W'(1));
        res_go_i = 1;
        chk(poke ? "R8 result unaffected by busy issue" : "R2 shift result", res_data_o, exp);
        @(negedge clk);
        res_go_i = 0;
        chk("R7 busy low after result go", W'(busy_o), W'(0));
        chk("R7 res_rel low after result go", W'(res_rel_o), W'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 busy after reset", W'(busy_o), W'(0));
        chk("R9 rels after reset", W'({opa_rel_o, opb_rel_o, res_rel_o}), W'(0));
        rst = 0;
        // R4: go with no release while idle is ignored
        @(negedge clk); opa_go_i = 1; opb_go_i = 1;
        @(negedge clk); opa_go_i = 0; opb_go_i = 0;
        chk("R4 go while idle ignored", W'({busy_o, opa_rel_o, opb_rel_o}), W'(0));
        txn(13, 2, 1, 0, 2, 0, 0);   // R2 right
        txn(3, 4, 0, 2, 0, 2, 0);    // R2 left, B before A
        txn(21, 0, 0, 1, 1, 1, 0);   // R3 zero amount left
        txn(16'hA5A5, 16'hFFF0, 1, 0, 0, 0, 0); // R3 zero amount right, low bits only
        txn(16'h8001, 15, 1, 4, 1, 3, 0);
        txn(16'hFFFF, 31, 0, 0, 5, 0, 0);      // R2 truncation, amount 15
        txn(7, 3, 0, 1, 0, 1, 1);    // R8 issue while busy
        // R1: releases rise the cycle after issue
        @(negedge clk); issue_i = 1; dir_i = 1;
        @(negedge clk); issue_i = 0;
        chk("R1 releases and busy after issue", W'({busy_o, opa_rel_o, opb_rel_o}), W'(3'b111));
        // R9: reset mid-transaction
        rst = 1;
        @(negedge clk);
        chk("R9 mid-transaction reset", W'({busy_o, opa_rel_o, opb_rel_o, res_rel_o}), W'(0));
        rst = 0;
        txn(1, 1, 0, 3, 3, 2, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule